// File: doc/BRIEF.md
# Power-of-Two Window Input Debounce Filter

This block cleans up one already-synchronized input pin before it reaches input sampling and edge detection. When filtering is switched on, a change on the raw input is passed on only after the new level has been held without interruption for a settling window. The window is counted in ticks of a shared millisecond strobe. Its length is two raised to a small exponent code, so the default 3-bit code selects 1, 2, 4 up to 128 ms. When filtering is switched off, the raw level goes straight to the output.

The enable and the exponent come from fields of the pin's control word: the enable at bit 8 and the exponent at bits 7:5. The register bus is outside this block, so they arrive here as separate inputs. Any change of either setting restarts the window count. The output keeps its level across that change.

Top module: `pow2_debounce`

## Requirements
- R1: While rst_n is low (synchronous, active low), the held level is loaded from raw_in on every rising clock edge. After release, filt_out starts from the level raw_in had at the last reset edge.
- R2: With db_enable high (1 = filtering on), once raw_in differs from filt_out, filt_out takes the new level on the clock edge that samples the 2^db_code-th ms_tick pulse counted since the difference began. It does not change on any earlier edge.
- R3: While filtering is on, any cycle in which raw_in equals filt_out clears the tick count. A later difference then needs a full new window, and filt_out does not change in the meantime.
- R4: With db_enable low, filt_out equals raw_in in the same cycle, whatever ms_tick does.
- R5: A clock edge at which db_code or db_enable differs from its value at the previous edge clears the tick count and does not change the held level. When filtering is switched on again, filt_out starts from the level raw_in had at the last edge while filtering was off.
- R6: Code 0 gives a window of exactly 1 tick and code 7 a window of exactly 128 ticks. The counter does not wrap at 128.
- R7: Cycles with ms_tick low do not advance the window. Only cycles with ms_tick high count toward it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| raw_in | input | 1 | Synchronized raw pin level |
| ms_tick | input | 1 | One-cycle millisecond strobe from the shared prescaler |
| db_enable | input | 1 | 1 = filtering on, 0 = bypass |
| db_code | input | CODE_W (3) | Window exponent: window = 2^code ticks |
| filt_out | output | 1 | Filtered level |

## Verification
The bench uses the default CODE_W of 3, so the counter is 8 bits wide and the longest window is 128 ticks. That reaches both extreme codes, 0 and 7, in a short run. The bench drives ms_tick itself, sometimes on every cycle and sometimes on one cycle in three. This keeps every window short and shows that cycles without a tick do not count. It also lets the bench place glitches, setting changes and a reset in the middle of a window at known tick counts.

// File: rtl/pow2db_pkg.sv
package pow2db_pkg;

  // Number of ticks in the settling window for a given exponent code.
  function automatic logic [63:0] window_len(input int unsigned code);
    return 64'(1) << code;
  endfunction

  // Tick count after one more qualifying tick.
  function automatic logic [63:0] bump(input logic [63:0] cur);
    return cur + 64'(1);
  endfunction

endpackage

// File: rtl/pow2db_cfg_track.sv
module pow2db_cfg_track #(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [CODE_W-1:0] code,
  output logic              cfg_change
);
  localparam int CFG_W = CODE_W + 1;

  logic [CFG_W-1:0] cfg_now;
  logic [CFG_W-1:0] cfg_q;

  assign cfg_now    = {en, code};
  assign cfg_change = (cfg_now != cfg_q);

  always_ff @(posedge clk) begin
    cfg_q <= cfg_now;
  end

  logic unused_rst;
  assign unused_rst = rst_n;
endmodule

// File: rtl/pow2db_window_cnt.sv
module pow2db_window_cnt #(
  parameter int CODE_W = 3,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              tick,
  input  logic [CODE_W-1:0] code,
  output logic              done,
  output logic [CNT_W-1:0]  count
);
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_nx;

  assign limit    = CNT_W'(pow2db_pkg::window_len(int'(code)));
  assign count_nx = CNT_W'(pow2db_pkg::bump(64'(count_q)));
  assign done     = tick && !clear && (count_nx == limit);
  assign count    = count_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear || done) begin
      count_q <= '0;
    end else if (tick) begin
      count_q <= count_nx;
    end
  end
endmodule

// File: rtl/pow2db_level_hold.sv
module pow2db_level_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  input  logic en,
  input  logic load,
  output logic level_q,
  output logic filt
);
  always_ff @(posedge clk) begin
    if (!rst_n || !en || load) begin
      level_q <= raw;
    end
  end

  assign filt = en ? level_q : raw;
endmodule

// File: rtl/pow2_debounce.sv
module pow2_debounce #(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              raw_in,
  input  logic              ms_tick,
  input  logic              db_enable,
  input  logic [CODE_W-1:0] db_code,
  output logic              filt_out
);
  localparam int MAX_EXP = (1 << CODE_W) - 1;
  localparam int CNT_W   = MAX_EXP + 1;

  logic             cfg_change;
  logic             held_level;
  logic             mismatch;
  logic             cnt_clear;
  logic             cnt_done;
  logic [CNT_W-1:0] cnt_val;

  assign mismatch  = (raw_in != held_level);
  assign cnt_clear = cfg_change || !db_enable || !mismatch;

  pow2db_cfg_track #(.CODE_W(CODE_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (db_enable),
    .code      (db_code),
    .cfg_change(cfg_change)
  );

  pow2db_window_cnt #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(cnt_clear),
    .tick (ms_tick),
    .code (db_code),
    .done (cnt_done),
    .count(cnt_val)
  );

  pow2db_level_hold u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw    (raw_in),
    .en     (db_enable),
    .load   (cnt_done),
    .level_q(held_level),
    .filt   (filt_out)
  );
endmodule

// File: rtl/pow2db_checker.sv
module pow2db_checker #(
  parameter int CODE_W = 3,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              raw_in,
  input logic              ms_tick,
  input logic              db_enable,
  input logic [CODE_W-1:0] db_code,
  input logic              filt_out,
  input logic              cnt_done,
  input logic [CNT_W-1:0]  cnt_val
);
  // R2: while filtering stays on, the output moves only after a window completed
  a_r2_change_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    (db_enable && $past(db_enable) && $past(rst_n) && (filt_out != $past(filt_out)))
      |-> $past(cnt_done));

  // R3: a matching cycle leaves the output where it is
  a_r3_match_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (db_enable && (raw_in == filt_out)) |=> (!db_enable || $stable(filt_out)));

  // R4: bypass when filtering is off
  a_r4_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    !db_enable |-> (filt_out == raw_in));

  // R5: a code change keeps the held level
  a_r5_cfg_change_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (db_enable && $past(db_enable) && $past(rst_n) && (db_code != $past(db_code)))
      |=> (!db_enable || $stable(filt_out)));

  // R7: no tick, no advance
  a_r7_no_tick_no_advance: assert property (@(posedge clk) disable iff (!rst_n)
    !ms_tick |=> ((cnt_val == '0) || (cnt_val == $past(cnt_val))));
endmodule

bind pow2_debounce pow2db_checker #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .raw_in   (raw_in),
  .ms_tick  (ms_tick),
  .db_enable(db_enable),
  .db_code  (db_code),
  .filt_out (filt_out),
  .cnt_done (cnt_done),
  .cnt_val  (cnt_val)
);

// File: tb/sim_pow2_debounce.sv
module sim_pow2_debounce;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic  val;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       raw_in;
  logic       ms_tick;
  logic       db_enable;
  logic [2:0] db_code;
  logic       filt_out;

  exp_t exp_q[$];
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   finished = 1'b0;

  // bench model state (value of the held level after the latest edge)
  logic       m_lvl;
  int         m_age;
  logic [3:0] m_cfg;

  always #(CLK_PERIOD/2) clk = ~clk;

  pow2_debounce #(.CODE_W(3)) u0 (
    .clk(clk), .rst_n(rst_n), .raw_in(raw_in), .ms_tick(ms_tick),
    .db_enable(db_enable), .db_code(db_code), .filt_out(filt_out)
  );

  // monitor: compare mid-cycle
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t it;
      it = exp_q.pop_front();
      n_chk++;
      if (filt_out !== it.val)
        begin
          n_fail++;
          $display("FAIL %s t=%0t filt_out actual=%b expected=%b", it.tag, $time, filt_out, it.val);
        end
    end
  end

  // model of the next edge, written from the requirements
  task automatic model_edge(input logic rs, input logic r, input logic t,
                            input logic e, input logic [2:0] c);
    if (!rs) begin
      m_lvl = r; m_age = 0; m_cfg = {e, c};
    end else if ({e, c} != m_cfg) begin
      m_cfg = {e, c}; m_age = 0;
      if (!e) m_lvl = r;
    end else if (!e) begin
      m_lvl = r; m_age = 0;
    end else if (r == m_lvl) begin
      m_age = 0;
    end else if (t) begin
      m_age = m_age + 1;
      if (m_age == (1 << c)) begin
        m_lvl = r; m_age = 0;
      end
    end
  endtask

  // driver: apply one cycle of inputs and push the expected output
  task automatic step(input logic rs, input logic r, input logic t,
                      input logic e, input logic [2:0] c, input string tag);
    exp_t it;
    @(posedge clk);
    #1;
    rst_n = rs; raw_in = r; ms_tick = t; db_enable = e; db_code = c;
    it.val = e ? m_lvl : r;
    it.tag = tag;
    exp_q.push_back(it);
    model_edge(rs, r, t, e, c);
  endtask

  task automatic run(input int n, input logic r, input int div,
                     input logic e, input logic [2:0] c, input string tag);
    for (int i = 0; i < n; i++)
      step(1'b1, r, ((i % div) == (div - 1)), e, c, tag);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    rst_n = 1'b0; raw_in = 1'b1; ms_tick = 1'b0; db_enable = 1'b1; db_code = 3'd2;
    m_lvl = 1'b1; m_age = 0; m_cfg = {1'b1, 3'd2};

    // R1: reset loads the raw level
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b1, 1'b1, 3'd2, "R1 reset");
    run(2, 1'b1, 1, 1'b1, 3'd2, "R1 after reset");

    // R2: code 2, tick every cycle, change held 6 cycles
    run(6, 1'b0, 1, 1'b1, 3'd2, "R2 window of 4");
    // R2: back to 1 with window 4
    run(6, 1'b1, 1, 1'b1, 3'd2, "R2 window of 4 rising");

    // R3: glitches restart the count
    run(3, 1'b0, 1, 1'b1, 3'd2, "R3 short pulse");
    run(1, 1'b1, 1, 1'b1, 3'd2, "R3 back to level");
    run(3, 1'b0, 1, 1'b1, 3'd2, "R3 second short pulse");
    run(1, 1'b1, 1, 1'b1, 3'd2, "R3 back again");
    run(6, 1'b0, 1, 1'b1, 3'd2, "R3 full window after restart");

    // R7: sparse ticks, code 1
    run(2, 1'b0, 1, 1'b1, 3'd1, "R7 settle code 1");
    run(9, 1'b1, 3, 1'b1, 3'd1, "R7 tick one in three");
    run(4, 1'b0, 1000, 1'b1, 3'd1, "R7 no ticks at all");

    // R6: extreme codes
    run(2, 1'b1, 1, 1'b1, 3'd0, "R6 settle code 0");
    run(3, 1'b0, 1, 1'b1, 3'd0, "R6 one tick window");
    run(2, 1'b1, 1, 1'b1, 3'd0, "R6 one tick window rising");
    run(2, 1'b1, 1, 1'b1, 3'd7, "R6 settle code 7");
    run(140, 1'b0, 1, 1'b1, 3'd7, "R6 window of 128");

    // R5: code change mid-window restarts the count and holds the level
    run(3, 1'b1, 1, 1'b1, 3'd2, "R5 partial window code 2");
    run(12, 1'b1, 1, 1'b1, 3'd3, "R5 new code 3 window");

    // R4: bypass with ticks and toggling raw
    for (int i = 0; i < 8; i++)
      step(1'b1, logic'(i % 2), 1'b1, 1'b0, 3'd2, "R4 bypass");
    // R5: re-enable starts from the level last seen while off
    run(1, 1'b0, 1, 1'b0, 3'd2, "R4 bypass last");
    run(3, 1'b1, 1000, 1'b1, 3'd2, "R5 re-enable holds");
    run(6, 1'b1, 1, 1'b1, 3'd2, "R5 window after re-enable");

    // R1: reset in the middle of a window with raw opposite to output
    run(2, 1'b0, 1, 1'b1, 3'd3, "R1 pre-reset");
    step(1'b0, 1'b0, 1'b0, 1'b1, 3'd3, "R1 mid-run reset");
    run(3, 1'b0, 1, 1'b1, 3'd3, "R1 after mid-run reset");

    @(posedge clk);
    @(negedge clk);
    #1;
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule